// File: doc/BRIEF.md
# Double-Buffered Converter Parallel Front End

This block is the digital front end of a single-channel digital-to-analog converter that is written over a parallel bus. A host drives an active-low select and an active-low write strobe together with a data word and two setting bits: a range doubler and a reference-buffer enable. When the write strobe rises while the block is selected, the word and both settings go into a first register (the staging register). A second register (the output register) drives the converter code and the two settings. It is loaded from the staging register by an active-low update strobe.

Two load modes are supported. If the update strobe is already low when the write strobe rises, the new word goes straight through to the output register on that write (write-tied mode). If the update strobe falls later, while the write strobe is high, the output register copies the staging register on that falling edge (standalone mode). An active-low zeroing input clears both registers at once, without waiting for a clock. The synchronous reset sets both registers to zero at power-on. An active-low sleep input is passed on to the converter as a registered sleep flag.

All strobes and bus lines are sampled by a two-flop synchronizer on the system clock. Edges are found by comparing each sample with the one before it.

Top module: `dac_pif`

## Requirements
- R1: A rising edge of `wr_n` while `cs_n` is low (at the last low sample of `wr_n`) loads `data_in`, `span2x_in` and `refbuf_in` into the staging register.
- R2: A rising edge of `wr_n` while `cs_n` is high leaves the staging register unchanged.
- R3: `span2x_in` and `refbuf_in` are captured on the same write as the data word, and they move to `span2x_q` and `refbuf_q` on the same loads as the word moves to `dac_code`.
- R4: Write-tied mode: if `upd_n` is low at the sample where `wr_n` is first seen high, and `cs_n` was low, the output register takes the new word at once.
- R5: Standalone mode: a falling edge of `upd_n` seen while `wr_n` is high copies the staging register into the output register.
- R6: A falling edge of `upd_n` while `wr_n` is still low does not copy the old staging contents. `dac_code` keeps its value until the write completes.
- R7: While `zero_n` is low, `dac_code`, `span2x_q` and `refbuf_q` are zero without any clock edge, and the staging register is zero too: a later standalone load yields zero.
- R8: Zeroing wins over everything else. No register is updated while `zero_n` is low, nor on the first two rising edges after it is released.
- R9: While `rst` is high at a rising edge, both registers go to zero and `sleep` goes to 0.
- R10: `sleep` is the inverse of `sleep_n`. Register contents are kept while `sleep` is 1.
- R11: Bit order is preserved: `data_in[WIDTH-1]` is the most significant bit and arrives at `dac_code[WIDTH-1]`.
- R12: Every output change caused by an input change appears on the third rising clock edge after that change: two edges for the synchronizer and one for the output register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset (power-on) |
| cs_n | input | 1 | Active-low select |
| wr_n | input | 1 | Active-low write strobe; capture on its rising edge |
| upd_n | input | 1 | Active-low update strobe for the output register |
| zero_n | input | 1 | Active-low zeroing, asserted asynchronously |
| sleep_n | input | 1 | Active-low sleep request |
| data_in | input | WIDTH | Data word, MSB at bit WIDTH-1 |
| span2x_in | input | 1 | Range doubler setting |
| refbuf_in | input | 1 | Reference buffer enable setting |
| dac_code | output | WIDTH | Code to the converter |
| span2x_q | output | 1 | Range doubler setting in effect |
| refbuf_q | output | 1 | Reference buffer setting in effect |
| sleep | output | 1 | Sleep flag to the converter |

## Verification
Apart from zeroing, every result reaches the outputs on the third rising edge after the input change that causes it. The bench drives its inputs on falling clock edges. A behavioural model keeps the last three sampled pin sets and applies the capture and load rules to them; its expectations are compared on every falling edge, half a cycle after the edge on which a result is due. Zeroing acts immediately, so that check is made a few nanoseconds after `zero_n` falls with no clock edge in between. The blocked window after release is two edges long. Each directed check waits at least four cycles after the strobe it concerns, so it always reads a value that has settled.

// File: rtl/dac_pif_pkg.sv
package dac_pif_pkg;
  typedef enum logic [1:0] {
    LD_NONE  = 2'd0,
    LD_TIED  = 2'd1,
    LD_ALONE = 2'd2
  } ld_kind_e;
endpackage

// File: rtl/dac_pif_sync.sv
module dac_pif_sync #(
  parameter int              WIDTH   = 1,
  parameter int              STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stg [STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) stg[i] <= RST_VAL;
        else     stg[i] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) stg[i] <= RST_VAL;
        else     stg[i] <= stg[i-1];
      end
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/dac_pif_clr.sv
module dac_pif_clr #(
  parameter int HOLD = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic zero_n,
  output logic blk
);
  logic [HOLD-1:0] sh;

  always_ff @(posedge clk or negedge zero_n) begin
    if (!zero_n)  sh <= '1;
    else if (rst) sh <= '0;
    else          sh <= {sh[HOLD-2:0], 1'b0};
  end

  assign blk = sh[HOLD-1];

  // R8: a low zeroing input keeps updates blocked at the next edge
  p_clear_blocks_r8: assert property (@(posedge clk) disable iff (rst)
    !zero_n |=> blk);
endmodule

// File: rtl/dac_pif_ctrl.sv
module dac_pif_ctrl
  import dac_pif_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     cs_s,
  input  logic     wr_s,
  input  logic     upd_s,
  output logic     cap_en,
  output ld_kind_e ld_kind
);
  logic cs_p, wr_p, upd_p;

  always_ff @(posedge clk) begin
    if (rst) begin
      cs_p  <= 1'b1;
      wr_p  <= 1'b1;
      upd_p <= 1'b1;
    end else begin
      cs_p  <= cs_s;
      wr_p  <= wr_s;
      upd_p <= upd_s;
    end
  end

  logic wr_rise, upd_fall;
  assign wr_rise  = !wr_p && wr_s;
  assign upd_fall = upd_p && !upd_s;
  assign cap_en   = wr_rise && !cs_p;

  always_comb begin
    ld_kind = LD_NONE;
    if (cap_en && !upd_s)
      ld_kind = LD_TIED;
    else if (upd_fall && wr_s)
      ld_kind = LD_ALONE;
  end

  // R6: no standalone load is decoded while the write strobe is low
  p_no_alone_in_write_r6: assert property (@(posedge clk) disable iff (rst)
    !wr_s |-> ld_kind != LD_ALONE);
endmodule

// File: rtl/dac_pif_regs.sv
module dac_pif_regs
  import dac_pif_pkg::*;
#(
  parameter int WIDTH = 10,
  localparam int PW   = WIDTH + 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          zero_n,
  input  logic          blk,
  input  logic          cap_en,
  input  ld_kind_e      ld_kind,
  input  logic [PW-1:0] d,
  output logic [PW-1:0] out_q
);
  logic [PW-1:0] stage_q;

  always_ff @(posedge clk or negedge zero_n) begin
    if (!zero_n) begin
      stage_q <= '0;
      out_q   <= '0;
    end else if (rst || blk) begin
      stage_q <= '0;
      out_q   <= '0;
    end else begin
      if (cap_en) stage_q <= d;
      case (ld_kind)
        LD_TIED:  out_q <= d;
        LD_ALONE: out_q <= stage_q;
        default:  out_q <= out_q;
      endcase
    end
  end

  // R7: zeroing input holds the output register at zero
  p_zero_holds_r7: assert property (@(posedge clk) disable iff (rst)
    !zero_n |-> out_q == '0);
  // R8: blocked cycles leave the output register at zero
  p_blocked_zero_r8: assert property (@(posedge clk) disable iff (rst)
    blk |=> out_q == '0);
  // R2: without a capture the staging register keeps its value or is zeroed
  p_stage_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !cap_en |=> (stage_q == $past(stage_q) || stage_q == '0));
  // R4: a write-tied load passes the captured word straight through
  p_tied_load_r4: assert property (@(posedge clk) disable iff (rst)
    (ld_kind == LD_TIED && !blk && zero_n) |=> (out_q == $past(d) || !zero_n));
  // R5: a standalone load copies the staging register
  p_alone_load_r5: assert property (@(posedge clk) disable iff (rst)
    (ld_kind == LD_ALONE && !blk && zero_n) |=> (out_q == $past(stage_q) || !zero_n));
endmodule

// File: rtl/dac_pif.sv
module dac_pif
  import dac_pif_pkg::*;
#(
  parameter int WIDTH       = 10,
  parameter int SYNC_STAGES = 2,
  parameter int CLR_HOLD    = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cs_n,
  input  logic             wr_n,
  input  logic             upd_n,
  input  logic             zero_n,
  input  logic             sleep_n,
  input  logic [WIDTH-1:0] data_in,
  input  logic             span2x_in,
  input  logic             refbuf_in,
  output logic [WIDTH-1:0] dac_code,
  output logic             span2x_q,
  output logic             refbuf_q,
  output logic             sleep
);
  localparam int PW = WIDTH + 2;
  localparam int SW = 4;

  logic [SW-1:0] strb_s;
  logic [PW-1:0] pay_s;
  logic [PW-1:0] out_q;
  logic          blk, cap_en;
  ld_kind_e      ld_kind;

  dac_pif_sync #(.WIDTH(SW), .STAGES(SYNC_STAGES), .RST_VAL({SW{1'b1}})) u_strb_sync (
    .clk (clk),
    .rst (rst),
    .d   ({cs_n, wr_n, upd_n, sleep_n}),
    .q   (strb_s)
  );

  dac_pif_sync #(.WIDTH(PW), .STAGES(SYNC_STAGES), .RST_VAL({PW{1'b0}})) u_pay_sync (
    .clk (clk),
    .rst (rst),
    .d   ({span2x_in, refbuf_in, data_in}),
    .q   (pay_s)
  );

  dac_pif_clr #(.HOLD(CLR_HOLD)) u_clr (
    .clk    (clk),
    .rst    (rst),
    .zero_n (zero_n),
    .blk    (blk)
  );

  dac_pif_ctrl u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .cs_s    (strb_s[3]),
    .wr_s    (strb_s[2]),
    .upd_s   (strb_s[1]),
    .cap_en  (cap_en),
    .ld_kind (ld_kind)
  );

  dac_pif_regs #(.WIDTH(WIDTH)) u_regs (
    .clk     (clk),
    .rst     (rst),
    .zero_n  (zero_n),
    .blk     (blk),
    .cap_en  (cap_en),
    .ld_kind (ld_kind),
    .d       (pay_s),
    .out_q   (out_q)
  );

  always_ff @(posedge clk) begin
    if (rst) sleep <= 1'b0;
    else     sleep <= !strb_s[0];
  end

  assign dac_code = out_q[WIDTH-1:0];
  assign refbuf_q = out_q[WIDTH];
  assign span2x_q = out_q[WIDTH+1];

  // R10: sleep follows the synchronized request one edge later
  p_sleep_follow_r10: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> sleep == !$past(strb_s[0]));
endmodule

// File: tb/dac_pif_tb.sv
module dac_pif_tb;
  localparam int W = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cs_n = 1'b1, wr_n = 1'b1, upd_n = 1'b1, zero_n = 1'b1, sleep_n = 1'b1;
  logic [W-1:0] data_in = '0;
  logic span2x_in = 1'b0, refbuf_in = 1'b0;
  logic [W-1:0] dac_code;
  logic span2x_q, refbuf_q, sleep;

  always #10 clk = ~clk;

  dac_pif #(.WIDTH(W)) u_dut (
    .clk(clk), .rst(rst), .cs_n(cs_n), .wr_n(wr_n), .upd_n(upd_n),
    .zero_n(zero_n), .sleep_n(sleep_n), .data_in(data_in),
    .span2x_in(span2x_in), .refbuf_in(refbuf_in), .dac_code(dac_code),
    .span2x_q(span2x_q), .refbuf_q(refbuf_q), .sleep(sleep)
  );

  int tests = 0;
  int fails = 0;
  bit started = 0;
  bit done = 0;

  task automatic chk(string tag, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // behavioural reference: pin history and rule application
  typedef struct packed {
    logic cs, wr, up, sl, g, b;
    logic [W-1:0] d;
  } pins_t;
  localparam pins_t IDLE = '{cs:1'b1, wr:1'b1, up:1'b1, sl:1'b1, g:1'b0, b:1'b0, d:'0};

  pins_t hist [3];
  logic [W+1:0] m_stage = '0, m_out = '0;
  logic m_sleep = 1'b0;
  int m_hold = 0;

  always @(posedge clk or negedge zero_n) begin
    if (clk) begin
      pins_t cur, prv;
      bit cap;
      started = 1;
      cur = hist[1];
      prv = hist[2];
      if (rst) begin
        for (int i = 0; i < 3; i++) hist[i] = IDLE;
        m_sleep = 1'b0;
        if (zero_n) begin
          m_hold = 0;
          m_stage = '0;
          m_out = '0;
        end
      end else begin
        m_sleep = !cur.sl;
        if (!zero_n || m_hold > 0) begin
          m_stage = '0;
          m_out = '0;
        end else begin
          cap = !prv.wr && cur.wr && !prv.cs;
          if (cap && !cur.up) m_out = {cur.g, cur.b, cur.d};
          else if (prv.up && !cur.up && cur.wr) m_out = m_stage;
          if (cap) m_stage = {cur.g, cur.b, cur.d};
        end
        if (zero_n && m_hold > 0) m_hold--;
        hist[2] = hist[1];
        hist[1] = hist[0];
        hist[0] = '{cs:cs_n, wr:wr_n, up:upd_n, sl:sleep_n, g:span2x_in, b:refbuf_in, d:data_in};
      end
    end
    if (!zero_n) begin
      m_stage = '0;
      m_out = '0;
      m_hold = 2;
    end
  end

  // R12: every output compared with the model half a cycle after each edge
  always @(negedge clk) begin
    if (started && !done) begin
      chk("R12 code", int'(dac_code), int'(m_out[W-1:0]));
      chk("R12 range", int'(span2x_q), int'(m_out[W+1]));
      chk("R12 refbuf", int'(refbuf_q), int'(m_out[W]));
      chk("R12 sleep", int'(sleep), int'(m_sleep));
    end
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_cycle(logic [W-1:0] v, logic g, logic b, logic sel, logic tied);
    @(negedge clk);
    cs_n = !sel; data_in = v; span2x_in = g; refbuf_in = b;
    @(negedge clk);
    wr_n = 1'b0;
    if (tied) upd_n = 1'b0;
    tick(2);
    wr_n = 1'b1;
    tick(1);
    cs_n = 1'b1; upd_n = 1'b1;
    tick(4);
  endtask

  task automatic ld_pulse();
    @(negedge clk);
    upd_n = 1'b0;
    tick(2);
    upd_n = 1'b1;
    tick(4);
  endtask

  initial begin
    tick(4);
    rst = 1'b0;
    tick(1);
    chk("R9 reset code", int'(dac_code), 0);
    chk("R9 reset sleep", int'(sleep), 0);

    // R4, R3: write-tied load
    wr_cycle(10'h2A5, 1'b1, 1'b0, 1'b1, 1'b1);
    chk("R4 tied code", int'(dac_code), 'h2A5);
    chk("R3 range bit", int'(span2x_q), 1);
    chk("R3 refbuf bit", int'(refbuf_q), 0);

    // R1, R5: plain write, then standalone load
    wr_cycle(10'h155, 1'b0, 1'b1, 1'b1, 1'b0);
    chk("R1 no load yet", int'(dac_code), 'h2A5);
    ld_pulse();
    chk("R5 alone code", int'(dac_code), 'h155);
    chk("R3 refbuf after load", int'(refbuf_q), 1);

    // R2: unselected write captures nothing
    wr_cycle(10'h3FF, 1'b1, 1'b1, 1'b0, 1'b0);
    ld_pulse();
    chk("R2 unselected", int'(dac_code), 'h155);

    // R6: update falls during write, before the new word completes
    wr_cycle(10'h0F0, 1'b0, 1'b0, 1'b1, 1'b0);
    @(negedge clk);
    cs_n = 1'b0; data_in = 10'h30C;
    @(negedge clk);
    wr_n = 1'b0;
    tick(1);
    upd_n = 1'b0;
    tick(5);
    chk("R6 held during write", int'(dac_code), 'h155);
    wr_n = 1'b1;
    tick(1);
    cs_n = 1'b1; upd_n = 1'b1;
    tick(4);
    chk("R6 new word after write", int'(dac_code), 'h30C);

    // R11: MSB position
    wr_cycle(10'h200, 1'b0, 1'b0, 1'b1, 1'b1);
    chk("R11 msb", int'(dac_code[W-1]), 1);
    chk("R11 word", int'(dac_code), 'h200);

    // R7: immediate zeroing without a clock edge
    @(negedge clk);
    #2 zero_n = 1'b0;
    #1 chk("R7 immediate zero", int'(dac_code), 0);
    // R8: a write-tied cycle during zeroing is ignored
    wr_cycle(10'h111, 1'b1, 1'b1, 1'b1, 1'b1);
    chk("R8 write under zeroing", int'(dac_code), 0);
    zero_n = 1'b1;
    tick(4);
    ld_pulse();
    chk("R7 staging cleared", int'(dac_code), 0);
    chk("R7 range cleared", int'(span2x_q), 0);

    // R10: sleep and retention
    wr_cycle(10'h1C3, 1'b1, 1'b0, 1'b1, 1'b1);
    sleep_n = 1'b0;
    tick(4);
    chk("R10 sleep set", int'(sleep), 1);
    chk("R10 code kept", int'(dac_code), 'h1C3);
    sleep_n = 1'b1;
    tick(4);
    chk("R10 sleep clear", int'(sleep), 0);
    chk("R10 code kept after wake", int'(dac_code), 'h1C3);

    // R9: reset in mid run
    @(negedge clk);
    rst = 1'b1;
    tick(2);
    rst = 1'b0;
    tick(1);
    chk("R9 mid reset code", int'(dac_code), 0);
    chk("R9 mid reset range", int'(span2x_q), 0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      tests++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule